// File: doc/BRIEF.md
# Block-Transfer Interrupt Sequencer

This block sits on the device side of a disk interface. It paces the data phase of sector read and sector write commands and decides when the host gets an interrupt. Single-sector commands interrupt once per sector. Multiple-sector commands interrupt once per block of sectors, where the block size is a configured value. The last block of a command may be shorter than the configured size.

A data-port strobe marks each 16-bit word that moves. The block never sees the data itself. The `buf_ready` input reports that the next read block sits in the device buffer. The `media_done` input reports that written data has been committed to the media. The `wcache_en` setting decides whether a write interrupt waits for the media. A read of the status register, signalled by `status_rd`, clears a pending interrupt. A multiple-sector command issued with no block size set is refused. It raises an abort flag together with an interrupt and has no data phase.

Top module: `multisector_irq_seq`

## Requirements
- R1: After a synchronous reset, `irq`, `drq`, `bsy` and `abort_err` are all low.
- R2: Codes 20h (read one sector), 30h (write one sector), C4h (read multiple) and C5h (write multiple) are accepted while idle. Any other code, and any command that arrives while a command is in progress, has no effect on the outputs.
- R3: A command with a sector count of zero, or a multiple command while `block_size` is zero, sets `abort_err` and `irq` in the next cycle and leaves `bsy` and `drq` low. An accepted command clears `abort_err`.
- R4: A read holds `bsy` high with `irq` and `drq` low until `buf_ready` is sampled high. One cycle later `irq` and `drq` are high and `bsy` is low.
- R5: The block size is 1 sector for single commands. For multiple commands it is the smaller of the remaining sector count and `block_size`, where a `block_size` above MAX_BLK (default 128) counts as MAX_BLK.
- R6: A sector is WPS words (default 256). `drq` stays high until the last word of the block has been strobed and falls in the next cycle.
- R7: A write raises `drq` the cycle after it is accepted, without `irq`. After each block, `bsy` is high with `drq` low until the block's interrupt.
- R8: With `wcache_en` high, `irq` rises two cycles after the last word of a write block.
- R9: With `wcache_en` low, a write block's `irq` waits until `media_done` is sampled high and rises one cycle later.
- R10: A `status_rd` pulse clears `irq` in the next cycle, unless a new interrupt is set in that same cycle.
- R11: At the write interrupt, `drq` rises again if sectors remain; otherwise the block goes idle. After the last read block, `bsy` and `drq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 8 | Command code |
| sector_count | input | CNT_W | Sectors requested |
| block_size | input | BLK_W | Configured sectors per interrupt, 0 = not set |
| wcache_en | input | 1 | Write caching enabled |
| buf_ready | input | 1 | Next read block is in the buffer |
| media_done | input | 1 | Written block committed to media |
| word_stb | input | 1 | One data-port word moved |
| status_rd | input | 1 | Host read of the status register |
| irq | output | 1 | Interrupt request |
| drq | output | 1 | Data request, data phase open |
| bsy | output | 1 | Device busy |
| abort_err | output | 1 | Last command aborted |

## Verification
The bench sweeps every block size from zero to beyond the cap against sector counts from zero up. The sweep covers each command kind and both cache settings, so it reaches short final blocks and the clamped block size. If a design miscounted the final partial block, it would hold `drq` high into words that never come. If it ignored the cap, it would drop `drq` too late. If it sent write interrupts without waiting for the media, the interrupt would appear before `media_done`. If it let a zero block size through, it would open a data phase instead of aborting. A stray command issued mid-transfer and an unknown opcode in idle must leave the outputs untouched.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam logic [7:0] OP_RD_ONE  = 8'h20;
  localparam logic [7:0] OP_WR_ONE  = 8'h30;
  localparam logic [7:0] OP_RD_MULT = 8'hC4;
  localparam logic [7:0] OP_WR_MULT = 8'hC5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RWAIT  = 2'd1,
    ST_XFER   = 2'd2,
    ST_COMMIT = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic known;
    logic mult;
    logic write;
  } cmd_class_t;
endpackage

// File: rtl/mbs_cmd_decode.sv
module mbs_cmd_decode
  import mbs_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int BLK_W = 8
) (
  input  logic [7:0]       code,
  input  logic [CNT_W-1:0] count,
  input  logic [BLK_W-1:0] blk,
  output cmd_class_t       cls,
  output logic             reject
);
  always_comb begin
    cls = '0;
    case (code)
      OP_RD_ONE:  cls = '{known: 1'b1, mult: 1'b0, write: 1'b0};
      OP_WR_ONE:  cls = '{known: 1'b1, mult: 1'b0, write: 1'b1};
      OP_RD_MULT: cls = '{known: 1'b1, mult: 1'b1, write: 1'b0};
      OP_WR_MULT: cls = '{known: 1'b1, mult: 1'b1, write: 1'b1};
      default:    cls = '0;
    endcase
    reject = cls.known && ((count == '0) || (cls.mult && (blk == '0)));
  end
endmodule

// File: rtl/mbs_chunk_sizer.sv
module mbs_chunk_sizer #(
  parameter int CNT_W   = 8,
  parameter int BLK_W   = 8,
  parameter int MAX_BLK = 128
) (
  input  logic [CNT_W-1:0] rem,
  input  logic [BLK_W-1:0] blk,
  input  logic             mult,
  output logic [CNT_W-1:0] chunk
);
  localparam int W = (CNT_W > BLK_W) ? CNT_W : BLK_W;
  logic [W-1:0] eff;
  logic [W-1:0] rem_w;

  always_comb begin
    rem_w = W'(rem);
    eff   = (W'(blk) > W'(MAX_BLK)) ? W'(MAX_BLK) : W'(blk);
    if (!mult)
      chunk = CNT_W'(1);
    else if (eff < rem_w)
      chunk = CNT_W'(eff);
    else
      chunk = rem;
  end
endmodule

// File: rtl/mbs_word_counter.sv
module mbs_word_counter #(
  parameter int WPS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic sector_end
);
  localparam int IDX_W = (WPS > 1) ? $clog2(WPS) : 1;
  logic [IDX_W-1:0] idx;

  assign sector_end = step && (idx == IDX_W'(WPS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear)
      idx <= '0;
    else if (step)
      idx <= sector_end ? '0 : idx + IDX_W'(1);
  end

  // R6: the word index never passes the last word of a sector
  a_r6_idx_range: assert property (@(posedge clk) disable iff (rst)
    idx <= IDX_W'(WPS - 1));
endmodule

// File: rtl/multisector_irq_seq.sv
module multisector_irq_seq
  import mbs_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int BLK_W   = 8,
  parameter int MAX_BLK = 128,
  parameter int WPS     = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic [CNT_W-1:0] sector_count,
  input  logic [BLK_W-1:0] block_size,
  input  logic             wcache_en,
  input  logic             buf_ready,
  input  logic             media_done,
  input  logic             word_stb,
  input  logic             status_rd,
  output logic             irq,
  output logic             drq,
  output logic             bsy,
  output logic             abort_err
);
  seq_state_t       state;
  cmd_class_t       cls;
  logic             reject;
  logic             wr_q, mult_q;
  logic [BLK_W-1:0] blk_q;
  logic [CNT_W-1:0] remaining, sec_left;
  logic [CNT_W-1:0] sz_rem, chunk;
  logic [BLK_W-1:0] sz_blk;
  logic             sz_mult;
  logic             sector_end;
  logic             in_xfer;

  assign in_xfer = (state == ST_XFER);

  mbs_cmd_decode #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_dec (
    .code(cmd_code), .count(sector_count), .blk(block_size),
    .cls(cls), .reject(reject)
  );

  // Idle: size from the incoming command; otherwise from latched state
  always_comb begin
    if (state == ST_IDLE) begin
      sz_rem  = sector_count;
      sz_blk  = block_size;
      sz_mult = cls.mult;
    end else begin
      sz_rem  = remaining;
      sz_blk  = blk_q;
      sz_mult = mult_q;
    end
  end

  mbs_chunk_sizer #(.CNT_W(CNT_W), .BLK_W(BLK_W), .MAX_BLK(MAX_BLK)) u_size (
    .rem(sz_rem), .blk(sz_blk), .mult(sz_mult), .chunk(chunk)
  );

  mbs_word_counter #(.WPS(WPS)) u_words (
    .clk(clk), .rst(rst), .clear(!in_xfer),
    .step(word_stb && in_xfer), .sector_end(sector_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      irq       <= 1'b0;
      drq       <= 1'b0;
      bsy       <= 1'b0;
      abort_err <= 1'b0;
      wr_q      <= 1'b0;
      mult_q    <= 1'b0;
      blk_q     <= '0;
      remaining <= '0;
      sec_left  <= '0;
    end else begin
      if (status_rd) irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid && cls.known) begin
            if (reject) begin
              abort_err <= 1'b1;
              irq       <= 1'b1;
            end else begin
              abort_err <= 1'b0;
              wr_q      <= cls.write;
              mult_q    <= cls.mult;
              blk_q     <= block_size;
              remaining <= sector_count;
              if (cls.write) begin
                state    <= ST_XFER;
                drq      <= 1'b1;
                sec_left <= chunk;
              end else begin
                state <= ST_RWAIT;
                bsy   <= 1'b1;
              end
            end
          end
        end
        ST_RWAIT: begin
          if (buf_ready) begin
            irq      <= 1'b1;
            drq      <= 1'b1;
            bsy      <= 1'b0;
            sec_left <= chunk;
            state    <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (sector_end) begin
            remaining <= remaining - CNT_W'(1);
            sec_left  <= sec_left - CNT_W'(1);
            if (sec_left == CNT_W'(1)) begin
              drq <= 1'b0;
              if (wr_q) begin
                bsy   <= 1'b1;
                state <= ST_COMMIT;
              end else if (remaining == CNT_W'(1)) begin
                state <= ST_IDLE;
              end else begin
                bsy   <= 1'b1;
                state <= ST_RWAIT;
              end
            end
          end
        end
        ST_COMMIT: begin
          if (wcache_en || media_done) begin
            irq <= 1'b1;
            bsy <= 1'b0;
            if (remaining == '0) begin
              state <= ST_IDLE;
            end else begin
              drq      <= 1'b1;
              sec_left <= chunk;
              state    <= ST_XFER;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: data phase and busy never overlap
  a_r6_drq_bsy_excl: assert property (@(posedge clk) disable iff (rst)
    !(drq && bsy));

  // R3: an aborted command opens no data phase and leaves busy low
  a_r3_abort_quiet: assert property (@(posedge clk) disable iff (rst)
    abort_err |-> (!bsy && !drq));

  // R4: a read interrupt follows a sampled buffer-ready
  a_r4_rd_irq_after_buf: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq) && !abort_err && !wr_q) |-> $past(buf_ready));

  // R9: without write caching the interrupt follows media commit
  a_r9_commit_wait: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq) && !abort_err && wr_q && !$past(wcache_en)) |-> $past(media_done));

  // R10: a status read with no new interrupt source clears irq
  a_r10_irq_clear: assert property (@(posedge clk) disable iff (rst)
    (status_rd && state == ST_XFER && !cmd_valid) |=> !irq);
endmodule

// File: tb/test_multisector_irq_seq.sv
`timescale 1ns/1ps
module test_multisector_irq_seq;
  localparam int WPS  = 8;
  localparam int MAXB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic [7:0] sector_count = 8'd0;
  logic [7:0] block_size = 8'd0;
  logic       wcache_en = 1'b0;
  logic       buf_ready = 1'b0;
  logic       media_done = 1'b0;
  logic       word_stb = 1'b0;
  logic       status_rd = 1'b0;
  logic       irq, drq, bsy, abort_err;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  multisector_irq_seq #(.CNT_W(8), .BLK_W(8), .MAX_BLK(MAXB), .WPS(WPS)) i_multisector_irq_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .sector_count(sector_count), .block_size(block_size), .wcache_en(wcache_en),
    .buf_ready(buf_ready), .media_done(media_done), .word_stb(word_stb),
    .status_rd(status_rd), .irq(irq), .drq(drq), .bsy(bsy), .abort_err(abort_err)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input logic e_irq, input logic e_drq, input logic e_bsy);
    chk(req, "irq", irq, e_irq);
    chk(req, "drq", drq, e_drq);
    chk(req, "bsy", bsy, e_bsy);
  endtask

  task automatic words(input int n);
    if (n > 0) begin
      word_stb = 1'b1;
      repeat (n) @(negedge clk);
      word_stb = 1'b0;
    end
  endtask

  task automatic clear_irq(input string req);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    chk(req, "irq cleared by status read", irq, 1'b0);
  endtask

  task automatic run_cmd(input logic [7:0] code, input int cnt, input int blk, input logic cache);
    bit mult, wr;
    int rem, eb, ch;
    mult = (code == 8'hC4) || (code == 8'hC5);
    wr   = (code == 8'h30) || (code == 8'hC5);
    eb   = (blk > MAXB) ? MAXB : blk;
    cmd_code = code; sector_count = 8'(cnt); block_size = 8'(blk); wcache_en = cache;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (cnt == 0 || (mult && blk == 0)) begin
      chk("R3", "abort_err", abort_err, 1'b1);
      outs("R3", 1'b1, 1'b0, 1'b0);
      clear_irq("R10");
      return;
    end
    chk("R3", "abort_err cleared", abort_err, 1'b0);
    rem = cnt;
    if (!wr) begin
      while (rem > 0) begin
        ch = mult ? ((eb < rem) ? eb : rem) : 1;
        outs("R4", 1'b0, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        outs("R4", 1'b0, 1'b0, 1'b1);
        buf_ready = 1'b1;
        @(negedge clk);
        buf_ready = 1'b0;
        outs("R4", 1'b1, 1'b1, 1'b0);
        clear_irq("R10");
        words(ch * WPS - 1);
        chk("R6", "drq before last word", drq, 1'b1);
        words(1);
        rem -= ch;
        chk("R5", "drq after block end", drq, 1'b0);
        chk("R11", "bsy after read block", bsy, rem > 0);
      end
    end else begin
      outs("R7", 1'b0, 1'b1, 1'b0);
      // R2: a second command during the data phase must change nothing
      cmd_code = 8'hC4; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      outs("R2", 1'b0, 1'b1, 1'b0);
      while (rem > 0) begin
        ch = mult ? ((eb < rem) ? eb : rem) : 1;
        words(ch * WPS - 1);
        chk("R6", "drq before last word", drq, 1'b1);
        words(1);
        rem -= ch;
        outs("R5", 1'b0, 1'b0, 1'b1);
        if (cache) begin
          @(negedge clk);
          chk("R8", "irq after cached block", irq, 1'b1);
        end else begin
          repeat (2) @(negedge clk);
          outs("R9", 1'b0, 1'b0, 1'b1);
          media_done = 1'b1;
          @(negedge clk);
          media_done = 1'b0;
          chk("R9", "irq after commit", irq, 1'b1);
        end
        chk("R11", "drq at write irq", drq, rem > 0);
        chk("R7", "bsy at write irq", bsy, 1'b0);
        clear_irq("R10");
      end
    end
    outs("R11", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    outs("R1", 1'b0, 1'b0, 1'b0);
    chk("R1", "abort_err", abort_err, 1'b0);

    // R2: unknown opcode in idle has no effect
    cmd_code = 8'hEC; sector_count = 8'd3; block_size = 8'd2; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    outs("R2", 1'b0, 1'b0, 1'b0);
    chk("R2", "abort_err", abort_err, 1'b0);

    for (int blk = 0; blk <= MAXB + 2; blk++)
      for (int cnt = 0; cnt <= 6; cnt++) begin
        run_cmd(8'h20, cnt, blk, 1'b1);
        run_cmd(8'h30, cnt, blk, 1'b0);
        run_cmd(8'hC4, cnt, blk, 1'b0);
        run_cmd(8'hC5, cnt, blk, 1'b1);
        run_cmd(8'hC5, cnt, blk, 1'b0);
      end

    // R10: abort interrupt cleared; accepted command clears abort flag (R3)
    run_cmd(8'hC4, 2, 0, 1'b0);
    chk("R3", "abort_err still set until next command", abort_err, 1'b1);
    run_cmd(8'h20, 1, 0, 1'b0);
    chk("R3", "abort_err after accepted command", abort_err, 1'b0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule